// File: doc/BRIEF.md
# Digital Dual-Tone Generator

This block produces a signed digital sample stream carrying one of sixteen telephone dual-tone pairs. A 4-bit code picks one frequency from a low group of four and one from a high group of four. Each group has its own integer divider, clocked from a single 3.579545 MHz reference, that advances a 32-step sine table. The two table outputs are added, with the high-group amplitude scaled up by about 2 dB so that it can make up for line loss. The D/A conversion and the analog smoothing that follow the stream are outside this block.

There are two ways to run it. In continuous mode the selected pair plays for as long as the transmitter is enabled, and writing a new code restarts the tone at once. In burst mode, writing a code starts a timed tone burst. A silent pause of fixed length follows the burst, and a one-cycle done pulse marks the end of that pause. Codes written while a burst or pause is running are held back until the next burst begins. When the transmitter is disabled the sample is forced to zero and the output-enable flag is low. A downstream driver can use that flag to float its pin.

Top module: `dtmf_tone_gen`

## Requirements
- R1: After reset, `sample` is 0 and both `outEn` and `burstDone` are 0.
- R2: The code on `codeIn` picks a row and a column. Codes 1,2,3,13 are row 0; 4,5,6,14 are row 1; 7,8,9,15 are row 2; 10,11,12,0 are row 3. Codes 1,4,7,11 are column 0; 2,5,8,10 are column 1; 3,6,9,12 are column 2; 13,14,15,0 are column 3. Rows 0..3 are 697, 770, 852 and 941 Hz. Columns 0..3 are 1209, 1336, 1477 and 1633 Hz.
- R3: For a tone of frequency f, the group's phase advances once every R cycles, where R = round(CLK_HZ / (32·f)). 32·R·f differs from CLK_HZ by at most 1.5 %. The phase is 0 during the first R cycles after a tone starts.
- R4: `sample` equals round(LO·sin(2π·pl/32)) + round(HI·sin(2π·ph/32)) within ±2 LSB, where pl and ph are the two group phases. The first sample of a tone appears two clock edges after the cycle that starts it.
- R5: HI = round(LO·1.259), which puts the high group about 2 dB above the low group. |sample| never exceeds LO+HI.
- R6: From the first edge after `txEnable` falls, `sample` is 0 and `outEn` is 0. Both stay there while the transmitter is disabled, whatever codes are written in that time.
- R7: In continuous mode (`burstMode`=0), a code write restarts the tone with the new pair at phase 0.
- R8: In burst mode, the tone lasts exactly BURST_CYC cycles. `sample` is then 0 for PAUSE_CYC cycles, and `burstDone` is high for one cycle right after the pause ends.
- R9: A code written during a burst or its pause does not change that burst. If such a write happened, the next burst starts straight after the pause with the latest written code.
- R10: In burst mode with no burst running, `sample` is 0 while `outEn` is 1, and a code write starts a burst.
- R11: `burstDone` never rises in continuous mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rstN | input | 1 | Active-low asynchronous reset |
| txEnable | input | 1 | Transmitter enable |
| burstMode | input | 1 | 1 selects timed bursts, 0 selects continuous tone |
| codeWr | input | 1 | One-cycle strobe that writes `codeIn` |
| codeIn | input | 4 | Tone-pair code |
| sample | output | SAMPLE_W | Signed summed sample |
| outEn | output | 1 | High while the output should be driven |
| burstDone | output | 1 | One-cycle pulse at the end of a burst's pause |

## Verification
The bench keeps the real 3.579545 MHz divider setting and the default amplitudes, so every one of the sixteen pairs is compared sample by sample against a sine model over more than a full high-group period. Burst and pause lengths are reduced to 6000 and 2000 cycles. This lets complete bursts, pauses, done pulses and a held-back code write fit in a short run, while the counters behave as they do at full length.

// File: rtl/dtmf_tx_pkg.sv
package dtmf_tx_pkg;

  localparam int PHASE_W = 5;
  localparam int STEPS   = 32;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_CONT,
    ST_BURST,
    ST_PAUSE
  } txState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic       load;     // restart both oscillators with row/col
    logic       toneOn;   // oscillators advance, sum is passed out
    logic       enable;   // transmitter enabled
    logic [1:0] row;
    logic [1:0] col;
  } txStrobe_t;

  // grp 0 = low group, grp 1 = high group; idx 0 is the lowest tone
  function automatic int groupFreq(input int grp, input int idx);
    int f;
    if (grp == 0) begin
      case (idx)
        0: f = 697;
        1: f = 770;
        2: f = 852;
        default: f = 941;
      endcase
    end else begin
      case (idx)
        0: f = 1209;
        1: f = 1336;
        2: f = 1477;
        default: f = 1633;
      endcase
    end
    return f;
  endfunction

  function automatic int divReload(input int clkHz, input int freq);
    return (clkHz + (STEPS * freq) / 2) / (STEPS * freq);
  endfunction

  // sin(k * 2pi/32) scaled by 65536, k = 0..8
  function automatic int quarterSine(input int k);
    int v;
    case (k)
      0: v = 0;
      1: v = 12785;
      2: v = 25080;
      3: v = 36410;
      4: v = 46341;
      5: v = 54491;
      6: v = 60547;
      7: v = 64277;
      default: v = 65536;
    endcase
    return v;
  endfunction

  function automatic int sineSample(input int amp, input int ph);
    int k;
    int mag;
    k = ph % 16;
    if (k > 8) k = 16 - k;
    mag = (amp * quarterSine(k) + 32768) / 65536;
    return ((ph % 32) >= 16) ? -mag : mag;
  endfunction

  function automatic logic [1:0] codeRow(input logic [3:0] c);
    logic [1:0] r;
    case (c)
      4'd1, 4'd2, 4'd3, 4'd13: r = 2'd0;
      4'd4, 4'd5, 4'd6, 4'd14: r = 2'd1;
      4'd7, 4'd8, 4'd9, 4'd15: r = 2'd2;
      default:                 r = 2'd3;
    endcase
    return r;
  endfunction

  function automatic logic [1:0] codeCol(input logic [3:0] c);
    logic [1:0] r;
    case (c)
      4'd1, 4'd4, 4'd7, 4'd11: r = 2'd0;
      4'd2, 4'd5, 4'd8, 4'd10: r = 2'd1;
      4'd3, 4'd6, 4'd9, 4'd12: r = 2'd2;
      default:                 r = 2'd3;
    endcase
    return r;
  endfunction

endpackage

// File: rtl/tone_osc.sv
module tone_osc
  import dtmf_tx_pkg::*;
#(
  parameter int CLK_HZ   = 3579545,
  parameter int GROUP    = 0,
  parameter int AMP      = 1000,
  parameter int SAMPLE_W = 13
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic                       load,
  input  logic                       run,
  input  logic [1:0]                 sel,
  output logic signed [SAMPLE_W-1:0] level
);

  localparam int MAX_RELOAD = divReload(CLK_HZ, groupFreq(GROUP, 0));
  localparam int DIV_W      = $clog2(MAX_RELOAD + 1);

  logic [DIV_W-1:0]          termTab [4];
  logic signed [SAMPLE_W-1:0] waveTab [STEPS];

  genvar gi;
  generate
    for (gi = 0; gi < 4; gi++) begin : g_term
      assign termTab[gi] = DIV_W'(divReload(CLK_HZ, groupFreq(GROUP, gi)) - 1);
    end
    for (gi = 0; gi < STEPS; gi++) begin : g_wave
      assign waveTab[gi] = SAMPLE_W'(sineSample(AMP, gi));
    end
  endgenerate

  logic [1:0]         selQ;
  logic [DIV_W-1:0]   divCnt;
  logic [PHASE_W-1:0] phase;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      selQ   <= '0;
      divCnt <= '0;
      phase  <= '0;
    end else if (load) begin
      selQ   <= sel;
      divCnt <= termTab[sel];
      phase  <= '0;
    end else if (run) begin
      if (divCnt == '0) begin
        divCnt <= termTab[selQ];
        phase  <= phase + 1'b1;
      end else begin
        divCnt <= divCnt - 1'b1;
      end
    end
  end

  assign level = waveTab[phase];

  // R3: phase only moves on a divider wrap
  p_phase_hold_r3: assert property (@(posedge clk) disable iff (!rstN)
    (!load && divCnt != '0) |=> $stable(phase));

  // R3: divider never exceeds the selected reload
  p_div_limit_r3: assert property (@(posedge clk) disable iff (!rstN)
    divCnt <= termTab[selQ]);

endmodule

// File: rtl/tone_datapath.sv
module tone_datapath
  import dtmf_tx_pkg::*;
#(
  parameter int CLK_HZ      = 3579545,
  parameter int LO_AMP      = 1000,
  parameter int TWIST_MILLI = 1259,
  parameter int SAMPLE_W    = 13
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  txStrobe_t                  strobe,
  output logic signed [SAMPLE_W-1:0] sample,
  output logic                       outEn
);

  localparam int HI_AMP = (LO_AMP * TWIST_MILLI + 500) / 1000;
  localparam int PEAK   = LO_AMP + HI_AMP;

  logic signed [SAMPLE_W-1:0] groupLevel [2];
  logic signed [SAMPLE_W-1:0] mixed;

  genvar g;
  generate
    for (g = 0; g < 2; g++) begin : g_group
      tone_osc #(
        .CLK_HZ  (CLK_HZ),
        .GROUP   (g),
        .AMP     ((g == 0) ? LO_AMP : HI_AMP),
        .SAMPLE_W(SAMPLE_W)
      ) u_osc (
        .clk  (clk),
        .rstN (rstN),
        .load (strobe.load),
        .run  (strobe.toneOn),
        .sel  ((g == 0) ? strobe.row : strobe.col),
        .level(groupLevel[g])
      );
    end
  endgenerate

  assign mixed = groupLevel[0] + groupLevel[1];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sample <= '0;
      outEn  <= 1'b0;
    end else begin
      sample <= (strobe.toneOn && strobe.enable) ? mixed : '0;
      outEn  <= strobe.enable;
    end
  end

  // R6: a floated output carries silence
  p_quiet_when_off_r6: assert property (@(posedge clk) disable iff (!rstN)
    !outEn |-> sample == '0);

  // R5: summed level stays within both amplitudes
  p_peak_limit_r5: assert property (@(posedge clk) disable iff (!rstN)
    (int'(sample) <= PEAK) && (int'(sample) >= -PEAK));

endmodule

// File: rtl/tone_ctrl.sv
module tone_ctrl
  import dtmf_tx_pkg::*;
#(
  parameter int BURST_CYC = 182556,
  parameter int PAUSE_CYC = 182556
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       txEnable,
  input  logic       burstMode,
  input  logic       codeWr,
  input  logic [3:0] codeIn,
  output txStrobe_t  strobe,
  output logic       burstDone
);

  localparam int LONGEST = (BURST_CYC > PAUSE_CYC) ? BURST_CYC : PAUSE_CYC;
  localparam int TIMER_W = $clog2(LONGEST + 1);

  txState_t         state, nextState;
  logic [TIMER_W-1:0] timer;
  logic [3:0]       txData;
  logic             pending;
  logic [3:0]       newCode;
  logic             load;
  logic             pauseEnd;

  assign newCode  = codeWr ? codeIn : txData;
  assign pauseEnd = (state == ST_PAUSE) && txEnable && burstMode && (timer == '0);

  always_comb begin
    load      = 1'b0;
    nextState = state;
    unique case (state)
      ST_IDLE: begin
        if (txEnable && !burstMode) begin
          load      = 1'b1;
          nextState = ST_CONT;
        end else if (txEnable && burstMode && (codeWr || pending)) begin
          load      = 1'b1;
          nextState = ST_BURST;
        end
      end
      ST_CONT: begin
        if (!txEnable || burstMode) nextState = ST_IDLE;
        else if (codeWr)            load = 1'b1;
      end
      ST_BURST: begin
        if (!txEnable || !burstMode) nextState = ST_IDLE;
        else if (timer == '0)        nextState = ST_PAUSE;
      end
      ST_PAUSE: begin
        if (!txEnable || !burstMode) nextState = ST_IDLE;
        else if (timer == '0) begin
          if (codeWr || pending) begin
            load      = 1'b1;
            nextState = ST_BURST;
          end else begin
            nextState = ST_IDLE;
          end
        end
      end
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state     <= ST_IDLE;
      timer     <= '0;
      txData    <= '0;
      pending   <= 1'b0;
      burstDone <= 1'b0;
    end else begin
      state     <= nextState;
      burstDone <= pauseEnd;
      if (codeWr) txData <= codeIn;
      if (!txEnable || load) pending <= 1'b0;
      else if (codeWr)       pending <= 1'b1;
      if (load)
        timer <= TIMER_W'(BURST_CYC - 1);
      else if (state == ST_BURST && nextState == ST_PAUSE)
        timer <= TIMER_W'(PAUSE_CYC - 1);
      else if ((state == ST_BURST || state == ST_PAUSE) && timer != '0)
        timer <= timer - 1'b1;
    end
  end

  assign strobe.load   = load;
  assign strobe.toneOn = (state == ST_CONT) || (state == ST_BURST);
  assign strobe.enable = txEnable;
  assign strobe.row    = codeRow(newCode);
  assign strobe.col    = codeCol(newCode);

  // R8: done pulse lasts one cycle
  p_done_single_r8: assert property (@(posedge clk) disable iff (!rstN)
    burstDone |=> !burstDone);

  // R8: done only follows a pause
  p_done_after_pause_r8: assert property (@(posedge clk) disable iff (!rstN)
    burstDone |-> $past(state) == ST_PAUSE);

  // R11: continuous tone never coincides with a done pulse
  p_no_done_cont_r11: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_CONT) |-> !burstDone);

  // R6: disabling always returns to idle
  p_off_idle_r6: assert property (@(posedge clk) disable iff (!rstN)
    !txEnable |=> state == ST_IDLE);

  // R8: pause timer stays inside its length
  p_pause_range_r8: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_PAUSE) |-> int'(timer) < PAUSE_CYC);

endmodule

// File: rtl/dtmf_tone_gen.sv
module dtmf_tone_gen
  import dtmf_tx_pkg::*;
#(
  parameter int CLK_HZ      = 3579545,
  parameter int LO_AMP      = 1000,
  parameter int TWIST_MILLI = 1259,
  parameter int SAMPLE_W    = 13,
  parameter int BURST_MS    = 51,
  parameter int PAUSE_MS    = 51,
  parameter int BURST_CYC   = CLK_HZ * BURST_MS / 1000,
  parameter int PAUSE_CYC   = CLK_HZ * PAUSE_MS / 1000
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic                       txEnable,
  input  logic                       burstMode,
  input  logic                       codeWr,
  input  logic [3:0]                 codeIn,
  output logic signed [SAMPLE_W-1:0] sample,
  output logic                       outEn,
  output logic                       burstDone
);

  txStrobe_t strobe;

  tone_ctrl #(
    .BURST_CYC(BURST_CYC),
    .PAUSE_CYC(PAUSE_CYC)
  ) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .txEnable (txEnable),
    .burstMode(burstMode),
    .codeWr   (codeWr),
    .codeIn   (codeIn),
    .strobe   (strobe),
    .burstDone(burstDone)
  );

  tone_datapath #(
    .CLK_HZ     (CLK_HZ),
    .LO_AMP     (LO_AMP),
    .TWIST_MILLI(TWIST_MILLI),
    .SAMPLE_W   (SAMPLE_W)
  ) u_dp (
    .clk   (clk),
    .rstN  (rstN),
    .strobe(strobe),
    .sample(sample),
    .outEn (outEn)
  );

endmodule

// File: tb/dtmf_tone_gen_tb.sv
module dtmf_tone_gen_tb;

  localparam int CLKHZ = 3579545;
  localparam int LO    = 1000;
  localparam int BCYC  = 6000;
  localparam int PCYC  = 2000;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic txEnable = 1'b0;
  logic burstMode = 1'b0;
  logic codeWr = 1'b0;
  logic [3:0] codeIn = '0;
  logic signed [12:0] sample;
  logic outEn;
  logic burstDone;

  int total = 0;
  int fails = 0;
  bit finished = 1'b0;
  int hiAmp;

  always #2 clk = ~clk;

  dtmf_tone_gen #(
    .BURST_CYC(BCYC),
    .PAUSE_CYC(PCYC)
  ) u_dut (
    .clk(clk), .rstN(rstN), .txEnable(txEnable), .burstMode(burstMode),
    .codeWr(codeWr), .codeIn(codeIn), .sample(sample), .outEn(outEn),
    .burstDone(burstDone)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int lowHz(input int r);
    int t[4] = '{697, 770, 852, 941};
    return t[r];
  endfunction

  function automatic int highHz(input int c);
    int t[4] = '{1209, 1336, 1477, 1633};
    return t[c];
  endfunction

  function automatic int tbReload(input int f);
    return $rtoi(real'(CLKHZ) / (32.0 * f) + 0.5);
  endfunction

  // keypad symbol for each code, then locate it in the row/column sets
  function automatic int findPos(input int code, input bit wantCol);
    string keys;
    string rows[4];
    keys = "D1234567890*#ABC";
    rows[0] = "123A"; rows[1] = "456B"; rows[2] = "789C"; rows[3] = "*0#D";
    for (int r = 0; r < 4; r++)
      for (int c = 0; c < 4; c++)
        if (rows[r][c] == keys[code]) return wantCol ? c : r;
    return 0;
  endfunction

  function automatic int wave(input int amp, input int ph);
    real v;
    v = amp * $sin(2.0 * 3.14159265358979 * ph / 32.0);
    return (v >= 0.0) ? $rtoi(v + 0.5) : -$rtoi(-v + 0.5);
  endfunction

  function automatic int expSample(input int code, input int n);
    int rl, rh;
    rl = tbReload(lowHz(findPos(code, 1'b0)));
    rh = tbReload(highHz(findPos(code, 1'b1)));
    return wave(LO, (n / rl) % 32) + wave(hiAmp, (n / rh) % 32);
  endfunction

  function automatic int absI(input int v);
    return (v < 0) ? -v : v;
  endfunction

  task automatic t_reset();
    check(sample == 0, "R1 sample", int'(sample), 0);
    check(outEn == 1'b0, "R1 outEn", int'(outEn), 0);
    check(burstDone == 1'b0, "R1 burstDone", int'(burstDone), 0);
  endtask

  task automatic t_reload_table();
    for (int i = 0; i < 8; i++) begin
      int f;
      real err;
      f = (i < 4) ? lowHz(i) : highHz(i - 4);
      err = (32.0 * tbReload(f) * f - CLKHZ) / CLKHZ;
      if (err < 0.0) err = -err;
      check(err <= 0.015, "R3 period error ppm", $rtoi(err * 1e6), 15000);
    end
  endtask

  // continuous tone for one code, compared against the sine model
  task automatic t_cont_code(input int code, input int len);
    int bad = 0, badAct = 0, badExp = 0, doneSeen = 0;
    @(negedge clk);
    burstMode = 1'b0; txEnable = 1'b0; codeWr = 1'b1; codeIn = 4'(code);
    @(negedge clk);
    codeWr = 1'b0; txEnable = 1'b1;
    for (int m = 0; m <= len; m++) begin
      @(posedge clk); @(negedge clk);
      if (burstDone) doneSeen++;
      if (m >= 1) begin
        int e;
        e = expSample(code, m - 1);
        if (absI(int'(sample) - e) > 2) begin
          if (bad == 0) begin badAct = int'(sample); badExp = e; end
          bad++;
        end
      end
      if (m == 1) check(outEn == 1'b1, "R4 outEn during tone", int'(outEn), 1);
    end
    check(bad == 0, $sformatf("R2 R3 R4 R5 code %0d waveform", code), badAct, badExp);
    check(doneSeen == 0, "R11 no done in continuous", doneSeen, 0);
  endtask

  task automatic t_disable();
    int bad = 0, badAct = 0;
    @(negedge clk);
    txEnable = 1'b0;
    for (int m = 0; m <= 60; m++) begin
      @(posedge clk); @(negedge clk);
      if (sample != 0 || outEn != 1'b0) begin
        if (bad == 0) badAct = int'(sample) + 100000 * int'(outEn);
        bad++;
      end
      codeWr = (m == 10 || m == 30);
      codeIn = (m == 10) ? 4'd1 : 4'd13;
      burstMode = (m >= 20);
    end
    codeWr = 1'b0; burstMode = 1'b0;
    check(bad == 0, "R6 silent and floated while disabled", badAct, 0);
  endtask

  task automatic t_restart();
    int bad = 0, badAct = 0, badExp = 0;
    t_cont_code(5, 1000);
    @(negedge clk);
    codeWr = 1'b1; codeIn = 4'd9;
    for (int m = 0; m <= 3000; m++) begin
      @(posedge clk); @(negedge clk);
      codeWr = 1'b0;
      if (m >= 1) begin
        int e;
        e = expSample(9, m - 1);
        if (absI(int'(sample) - e) > 2) begin
          if (bad == 0) begin badAct = int'(sample); badExp = e; end
          bad++;
        end
      end
    end
    check(bad == 0, "R7 restart on write", badAct, badExp);
  endtask

  task automatic enter_burst_idle();
    int bad = 0;
    @(negedge clk);
    txEnable = 1'b0;
    @(negedge clk);
    burstMode = 1'b1; txEnable = 1'b1;
    for (int m = 0; m < 20; m++) begin
      @(posedge clk); @(negedge clk);
      if (sample != 0 || outEn != 1'b1 || burstDone) bad++;
    end
    check(bad == 0, "R10 idle burst mode is silent but driven", bad, 0);
  endtask

  // one burst; if lateCode >= 0 it is written during the burst
  task automatic t_burst(input int code, input int lateCode);
    int toneBad = 0, silBad = 0, doneBad = 0, nextBad = 0;
    int act1 = 0, exp1 = 0, last;
    last = (lateCode >= 0) ? BCYC + PCYC + 2000 : BCYC + PCYC + 5;
    @(negedge clk);
    codeWr = 1'b1; codeIn = 4'(code);
    for (int m = 0; m <= last; m++) begin
      @(posedge clk); @(negedge clk);
      codeWr = 1'b0;
      if (lateCode >= 0 && m == 100) begin codeWr = 1'b1; codeIn = 4'(lateCode); end
      if (m >= 1 && m <= BCYC) begin
        int e;
        e = expSample(code, m - 1);
        if (absI(int'(sample) - e) > 2) begin
          if (toneBad == 0) begin act1 = int'(sample); exp1 = e; end
          toneBad++;
        end
      end else if (m > BCYC && m <= BCYC + PCYC) begin
        if (sample != 0) silBad++;
      end else if (m > BCYC + PCYC) begin
        if (lateCode >= 0) begin
          if (absI(int'(sample) - expSample(lateCode, m - (BCYC + PCYC + 1))) > 2) nextBad++;
        end else if (sample != 0) silBad++;
      end
      if (burstDone != (m == BCYC + PCYC)) doneBad++;
    end
    check(toneBad == 0, "R8 R9 burst tone keeps its code", act1, exp1);
    check(silBad == 0, "R8 pause silence", silBad, 0);
    check(doneBad == 0, "R8 done pulse timing", doneBad, 0);
    if (lateCode >= 0)
      check(nextBad == 0, "R9 held code starts next burst", nextBad, 0);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      total++; fails++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

  initial begin
    hiAmp = $rtoi(LO * (10.0 ** (2.0 / 20.0)) + 0.5);
    repeat (5) @(negedge clk);
    t_reset();
    rstN = 1'b1;
    t_reload_table();
    check(hiAmp == 1259, "R5 twist amplitude", hiAmp, 1259);
    for (int c = 0; c < 16; c++) t_cont_code(c, 4200);
    t_disable();
    t_restart();
    enter_burst_idle();
    t_burst(3, -1);
    t_burst(7, 12);
    finished = 1'b1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

endmodule